// File: doc/BRIEF.md
# Sector Group Protection Gate

This block sits in front of a flash array controller and rules on every program or erase request before any array timing starts. The byte address space is cut into equal sectors, and each run of adjacent sectors forms a protection group that carries a single lock bit. A program request names one byte address. An erase request carries a bitmap of the sectors to clear, or a flag that selects the whole device. The gate turns either kind of request into a filtered sector bitmap that keeps only the sectors the operation may touch. It also gives an allow flag, and an empty flag for the case where nothing is left.

Lock bits are changed only through a separate privileged write port, and all of them are clear after reset. A temporary-unlock input makes every group count as unlocked for as long as it is held. The stored lock bits are not changed by it, so protection comes back by itself when the input drops. A supply-lockout input refuses every request while it is active. The verdict is registered and appears in the cycle after the request strobe.

Top module: `sector_guard`

## Requirements
- R1: After reset the gate gives res_valid=0, res_allow=0, res_mask=0 and res_empty=1, and all group lock bits are clear.
- R2: res_valid is 1 in exactly the cycle after a cycle with req_valid=1, and 0 otherwise. The verdict for that request is on the result outputs in that same cycle.
- R3: A program request (req_erase=0) is allowed only when the lock bit of group req_addr[20:18] is clear. When it is allowed, res_mask is one-hot with bit req_addr[20:16] set. When it is refused, res_mask is 0.
- R4: For an erase request (req_erase=1, req_whole=0), res_mask equals req_mask with bits 4g to 4g+3 cleared for every locked group g. Bit n of a mask stands for sector n.
- R5: An erase request with req_whole=1 uses an all-ones sector bitmap in place of req_mask and then applies the same group filtering.
- R6: res_empty is 1 exactly when res_mask is 0, and res_allow is always the inverse of res_empty.
- R7: While tmp_unlock=1 in the request cycle, every group counts as unlocked. Dropping tmp_unlock brings back the stored lock bits unchanged.
- R8: While supply_lock=1 in the request cycle, the verdict is res_mask=0 and res_allow=0, whatever the lock bits and the temporary unlock.
- R9: A cycle with lock_we=1 sets the lock bit of group lock_grp to lock_val. A request made in that same cycle still sees the old bit, and later requests see the new one.
- R10: When no request is strobed, res_allow, res_mask and res_empty keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request strobe |
| req_erase | input | 1 | 0 = program, 1 = erase |
| req_addr | input | 21 | Byte address (program) |
| req_mask | input | 32 | Requested erase sector bitmap |
| req_whole | input | 1 | Erase the whole device |
| tmp_unlock | input | 1 | Temporary unlock of all groups while held |
| supply_lock | input | 1 | Supply lockout, refuses all requests |
| lock_we | input | 1 | Lock bit write strobe |
| lock_grp | input | 3 | Group index for the lock write |
| lock_val | input | 1 | New lock bit value |
| res_valid | output | 1 | Verdict valid pulse |
| res_allow | output | 1 | Request may proceed |
| res_mask | output | 32 | Sectors the operation may touch |
| res_empty | output | 1 | Filtered bitmap is empty |

## Verification
The bench builds the gate with its default geometry: 21 address bits, 5 sector-index bits and 3 group-index bits. That gives 32 sectors in 8 groups of four. With these values every group boundary of the 32-bit bitmap lies inside the stimulus. The highest sector and the highest group can be reached, and a lock write can land in the same cycle as a request aimed at that group. Directed cases cover the temporary-unlock and supply-lockout precedence. After them comes a random run that mixes lock writes and both request kinds.

// File: rtl/sg_pkg.sv
package sg_pkg;

    localparam int SG_ADDR_W = 21;
    localparam int SG_SECT_W = 5;
    localparam int SG_GRP_W  = 3;

    typedef enum logic {
        OP_PROG  = 1'b0,
        OP_ERASE = 1'b1
    } sg_op_e;

    function automatic sg_op_e op_of(input logic erase_bit);
        return erase_bit ? OP_ERASE : OP_PROG;
    endfunction

endpackage

// File: rtl/sg_lock_bank.sv
module sg_lock_bank #(
    parameter int GRP_W  = 3,
    localparam int GROUPS = 1 << GRP_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [GRP_W-1:0]  idx,
    input  logic              val,
    output logic [GROUPS-1:0] locked
);
    for (genvar g = 0; g < GROUPS; g++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)
                locked[g] <= 1'b0;
            else if (we && idx == GRP_W'(g))
                locked[g] <= val;
        end
    end
endmodule

// File: rtl/sg_sector_expand.sv
module sg_sector_expand #(
    parameter int SECT_W  = 5,
    parameter int GRP_W   = 3,
    localparam int SECTORS = 1 << SECT_W,
    localparam int GROUPS  = 1 << GRP_W,
    localparam int SPG     = SECTORS / GROUPS
) (
    input  logic [GROUPS-1:0]  locked,
    input  logic               tmp_unlock,
    output logic [SECTORS-1:0] blocked
);
    for (genvar s = 0; s < SECTORS; s++) begin : g_sect
        assign blocked[s] = locked[s / SPG] & ~tmp_unlock;
    end
endmodule

// File: rtl/sg_decide.sv
module sg_decide
    import sg_pkg::*;
#(
    parameter int ADDR_W  = 21,
    parameter int SECT_W  = 5,
    localparam int SECTORS = 1 << SECT_W
) (
    input  sg_op_e             op,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [SECTORS-1:0] mask,
    input  logic               whole,
    input  logic               supply_lock,
    input  logic [SECTORS-1:0] blocked,
    output logic [SECTORS-1:0] grant
);
    logic [SECT_W-1:0]  sidx;
    logic [SECTORS-1:0] wanted;

    assign sidx = addr[ADDR_W-1 -: SECT_W];

    always_comb begin
        if (op == OP_PROG)
            wanted = {{(SECTORS-1){1'b0}}, 1'b1} << sidx;
        else if (whole)
            wanted = '1;
        else
            wanted = mask;
        grant = supply_lock ? '0 : (wanted & ~blocked);
    end
endmodule

// File: rtl/sector_guard.sv
module sector_guard
    import sg_pkg::*;
#(
    parameter int ADDR_W  = SG_ADDR_W,
    parameter int SECT_W  = SG_SECT_W,
    parameter int GRP_W   = SG_GRP_W,
    localparam int SECTORS = 1 << SECT_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic               req_erase,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [SECTORS-1:0] req_mask,
    input  logic               req_whole,
    input  logic               tmp_unlock,
    input  logic               supply_lock,
    input  logic               lock_we,
    input  logic [GRP_W-1:0]   lock_grp,
    input  logic               lock_val,
    output logic               res_valid,
    output logic               res_allow,
    output logic [SECTORS-1:0] res_mask,
    output logic               res_empty
);
    localparam int GROUPS = 1 << GRP_W;

    logic [GROUPS-1:0]  locked;
    logic [SECTORS-1:0] blocked;
    logic [SECTORS-1:0] grant;

    sg_lock_bank #(.GRP_W(GRP_W)) u_bank (
        .clk(clk), .rst(rst), .we(lock_we), .idx(lock_grp),
        .val(lock_val), .locked(locked)
    );

    sg_sector_expand #(.SECT_W(SECT_W), .GRP_W(GRP_W)) u_expand (
        .locked(locked), .tmp_unlock(tmp_unlock), .blocked(blocked)
    );

    sg_decide #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_decide (
        .op(op_of(req_erase)), .addr(req_addr), .mask(req_mask),
        .whole(req_whole), .supply_lock(supply_lock),
        .blocked(blocked), .grant(grant)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            res_allow <= 1'b0;
            res_mask  <= '0;
            res_empty <= 1'b1;
        end else begin
            res_valid <= req_valid;
            if (req_valid) begin
                res_mask  <= grant;
                res_allow <= |grant;
                res_empty <= ~|grant;
            end
        end
    end
endmodule

// File: rtl/sg_guard_chk.sv
module sg_guard_chk #(
    parameter int SECTORS = 32
) (
    input logic               clk,
    input logic               rst,
    input logic               req_valid,
    input logic               req_erase,
    input logic               req_whole,
    input logic               supply_lock,
    input logic [SECTORS-1:0] req_mask,
    input logic               res_valid,
    input logic               res_allow,
    input logic               res_empty,
    input logic [SECTORS-1:0] res_mask
);
    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> res_valid);
    assert_valid_idle_R2: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !res_valid);
    assert_prog_onehot_R3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_erase) |=> $countones(res_mask) <= 1);
    assert_erase_subset_R4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_erase && !req_whole) |=> (res_mask & ~$past(req_mask)) == '0);
    assert_allow_nonempty_R6: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> (res_allow == (res_mask != '0)));
    assert_lockout_R8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && supply_lock) |=> (!res_allow && res_mask == '0));
    assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> ($stable(res_mask) && $stable(res_allow) && $stable(res_empty)));
endmodule

bind sector_guard sg_guard_chk #(.SECTORS(SECTORS)) u_guard_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_erase(req_erase),
    .req_whole(req_whole), .supply_lock(supply_lock), .req_mask(req_mask),
    .res_valid(res_valid), .res_allow(res_allow), .res_empty(res_empty),
    .res_mask(res_mask)
);

// File: tb/test_sector_guard.sv
module test_sector_guard;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 0, req_erase = 0, req_whole = 0;
    logic [20:0] req_addr = '0;
    logic [31:0] req_mask = '0;
    logic        tmp_unlock = 0, supply_lock = 0;
    logic        lock_we = 0, lock_val = 0;
    logic [2:0]  lock_grp = '0;
    logic        res_valid, res_allow, res_empty;
    logic [31:0] res_mask;

    int vectors = 0;
    int miscompares = 0;
    logic [7:0]  m_lock;
    logic        e_valid, e_allow, e_empty;
    logic [31:0] e_mask;

    always #4 clk = ~clk;

    sector_guard i_sector_guard (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_erase(req_erase),
        .req_addr(req_addr), .req_mask(req_mask), .req_whole(req_whole),
        .tmp_unlock(tmp_unlock), .supply_lock(supply_lock),
        .lock_we(lock_we), .lock_grp(lock_grp), .lock_val(lock_val),
        .res_valid(res_valid), .res_allow(res_allow),
        .res_mask(res_mask), .res_empty(res_empty)
    );

    task automatic compare(input string tag);
        vectors++;
        if (res_valid !== e_valid || res_allow !== e_allow ||
            res_mask !== e_mask || res_empty !== e_empty) begin
            miscompares++;
            $display("FAIL %s: got v=%0b a=%0b m=%08h e=%0b, expected v=%0b a=%0b m=%08h e=%0b",
                     tag, res_valid, res_allow, res_mask, res_empty,
                     e_valid, e_allow, e_mask, e_empty);
        end
    endtask

    // reference model: predict, update lock bits, clock, compare
    task automatic tick(input string tag);
        logic [31:0] want;
        int grp;
        e_valid = req_valid;
        if (req_valid) begin
            if (!req_erase) begin
                grp  = int'(req_addr[20:18]);
                want = (m_lock[grp] && !tmp_unlock) ? 32'h0 : (32'h1 << req_addr[20:16]);
            end else begin
                want = req_whole ? 32'hFFFF_FFFF : req_mask;
                for (int s = 0; s < 32; s++)
                    if (m_lock[s / 4] && !tmp_unlock) want[s] = 1'b0;
            end
            if (supply_lock) want = 32'h0;
            e_mask  = want;
            e_empty = (want == 32'h0);
            e_allow = (want != 32'h0);
        end
        if (lock_we) m_lock[lock_grp] = lock_val;
        @(posedge clk);
        @(negedge clk);
        compare(tag);
        req_valid = 0; lock_we = 0;
    endtask

    task automatic prog(input logic [20:0] a);
        req_valid = 1; req_erase = 0; req_addr = a; req_whole = 0;
    endtask

    task automatic erase(input logic [31:0] m, input logic w);
        req_valid = 1; req_erase = 1; req_mask = m; req_whole = w;
    endtask

    task automatic setlock(input int g, input logic v);
        lock_we = 1; lock_grp = 3'(g); lock_val = v;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: got hang, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        m_lock = '0;
        e_valid = 0; e_allow = 0; e_mask = '0; e_empty = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        compare("R1 reset state");
        rst = 0;
        tick("R1 idle after reset");
        prog(21'h1F_0012);      tick("R1 top sector unlocked after reset");
        prog(21'h05_0000);      tick("R3 program unlocked sector 5");
        setlock(2, 1); prog(21'h09_1234); tick("R9 same-cycle write sees old bit");
        prog(21'h09_1234);      tick("R3 program in locked group 2");
        prog(21'h0C_0000);      tick("R3 program sector 12 group 3");
        erase(32'hFFFF_FFFF, 0); tick("R4 erase all bits with group 2 locked");
        erase(32'h0000_0F00, 0); tick("R6 erase only locked sectors is empty");
        setlock(7, 1);
        erase(32'h1234_5678, 1); tick("R5 whole device erase");
        erase(32'hF000_0001, 0); tick("R4 top group locked");
        tmp_unlock = 1;
        prog(21'h1F_FFFF);      tick("R7 program under temporary unlock");
        erase(32'h0, 1);        tick("R7 whole erase under temporary unlock");
        tmp_unlock = 0;
        prog(21'h1F_FFFF);      tick("R7 lock restored after release");
        supply_lock = 1;
        prog(21'h00_0000);      tick("R8 lockout program");
        tmp_unlock = 1;
        erase(32'hFFFF_FFFF, 1); tick("R8 lockout overrides unlock");
        supply_lock = 0; tmp_unlock = 0;
        tick("R10 hold 1");
        tick("R10 hold 2");
        setlock(2, 0);          tick("R9 clear group 2");
        prog(21'h0A_0000);      tick("R9 cleared group allows program");
        erase(32'h0, 0);        tick("R6 empty request mask");
        for (int i = 0; i < 400; i++) begin
            if ($urandom_range(0, 3) == 0) setlock(int'($urandom_range(0, 7)), 1'($urandom));
            if ($urandom_range(0, 2) != 0) begin
                if ($urandom % 2 == 0) prog(21'($urandom));
                else erase($urandom & $urandom, $urandom_range(0, 7) == 0);
            end
            tmp_unlock  = ($urandom_range(0, 7) == 0);
            supply_lock = ($urandom_range(0, 9) == 0);
            tick("R2 random mix");
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule